// File: doc/BRIEF.md
# Maskable Interrupt Status Bank

This block collects event indications from the rest of a chip into a bank of status registers and condenses them into one interrupt line. Each status register has a companion mask register. A one-cycle event pulse sets its status bit. A small set of level alarms sets its bits through edge detection. A bit whose mask is clear may drive the interrupt line. A processor reads a selected status register through a simple read strobe. The read returns a snapshot and clears the bits that the snapshot showed.

Two run-time controls change the behaviour. A visibility control lets masked events be recorded and read back without ever raising the interrupt. An edge control makes the alarm bits fire either on the rising edge of the alarm level only, or on both of its edges. An elaboration parameter chooses how the line is driven: push-pull, with a selectable active level, or open-drain, where the block only enables a pull-down.

Top module: `irq_status_bank`

## Requirements
- R1: An event pulse on an unmasked bit sets that status bit at the next clock edge, and from that edge the interrupt is active.
- R2: A set status bit whose mask bit is 1 never makes the interrupt active.
- R3: With visibility off, an event on a masked bit is not recorded, and a read shows only the unmasked bits of the register (rd_data bit = status AND NOT mask).
- R4: With visibility on, an event on a masked bit is recorded and a read shows it, while the interrupt stays inactive.
- R5: A read of register k (rd_en high, rd_sel = k) loads rd_data at the clock edge with the bits shown, and clears exactly those bits at the same edge. With visibility on, this is every active bit, masked or not. No status bit is cleared without a read.
- R6: An event that arrives in the same cycle as a read of its register leaves its bit set after the read.
- R7: Alarm input i maps to flat status bit ALARM_BASE+i (flat bit = register*REG_W + bit). With alarm_any_edge low, only a 0-to-1 change of the alarm level sets that bit, and a 1-to-0 change has no effect.
- R8: With alarm_any_edge high, both a 0-to-1 and a 1-to-0 change of the alarm level set the alarm's status bit.
- R9: The interrupt is active exactly when some status bit in any register of the bank is set and unmasked.
- R10: In push-pull mode, irq_oe is always 1 and irq_out equals IRQ_ACTIVE_HIGH when the interrupt is active. In open-drain mode, irq_out is 0 and irq_oe is 1 exactly when the interrupt is active. The default is push-pull, active high.
- R11: After reset, all status bits are 0, all mask bits are 1, rd_data is 0 and the interrupt is inactive.
- R12: A mask write (mask_wr high, mask_sel = k) loads mask_wdata into mask register k at the clock edge. A mask bit of 1 masks its status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_pulse | input | NUM_REGS*REG_W | One-cycle event pulses, one per status bit (flat index) |
| alarm_lvl | input | NUM_ALARMS | Alarm level flags |
| alarm_any_edge | input | 1 | 1: alarms fire on both edges; 0: rising only |
| visible_mode | input | 1 | 1: masked events are recorded and readable |
| mask_wr | input | 1 | Mask register write strobe |
| mask_sel | input | SEL_W | Mask register index |
| mask_wdata | input | REG_W | Mask write data |
| rd_en | input | 1 | Status read-and-clear strobe |
| rd_sel | input | SEL_W | Status register index |
| rd_data | output | REG_W | Snapshot returned by the last read |
| irq_out | output | 1 | Interrupt line value |
| irq_oe | output | 1 | Interrupt line output enable |

## Verification
The risky coincidence is a clearing read and a new event that hit the same register in the same cycle. The new event must survive the clear, and it must not show up in the snapshot that the read returns. The bench provokes this by raising the event pulse and the read strobe on the same clock edge. It then expects the old value in rd_data and the interrupt still active. A second read must return the new bit. A second coincidence, an alarm edge that lands while the register is being read, is covered by the same rule and by a property in the checker.

// File: rtl/irq_pkg.sv
package irq_pkg;
   typedef enum logic {
      DRV_PUSH_PULL  = 1'b0,
      DRV_OPEN_DRAIN = 1'b1
   } irq_drv_e;
endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lvl,
   input  logic         any_edge,
   output logic [N-1:0] evt
);
   logic [N-1:0] prev_q;
   logic [N-1:0] rise;
   logic [N-1:0] fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= lvl;
   end

   assign rise = lvl & ~prev_q;
   assign fall = ~lvl & prev_q;
   assign evt  = any_edge ? (rise | fall) : rise;
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set,
   input  logic         visible,
   input  logic         rd_hit,
   input  logic         mask_hit,
   input  logic [W-1:0] mask_wdata,
   output logic [W-1:0] status_q,
   output logic [W-1:0] mask_q,
   output logic [W-1:0] view,
   output logic         pend
);
   logic [W-1:0] clr;
   logic [W-1:0] rec;

   assign view = visible ? status_q : (status_q & ~mask_q);
   assign clr  = rd_hit ? view : '0;
   assign rec  = visible ? set : (set & ~mask_q);
   assign pend = |(status_q & ~mask_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= '0;
         mask_q   <= '1;
      end else begin
         status_q <= (status_q & ~clr) | rec;
         if (mask_hit) mask_q <= mask_wdata;
      end
   end
endmodule

// File: rtl/irq_out_driver.sv
module irq_out_driver #(
   parameter irq_pkg::irq_drv_e DRV_MODE       = irq_pkg::DRV_PUSH_PULL,
   parameter bit                IRQ_ACTIVE_HIGH = 1'b1
) (
   input  logic pending,
   output logic irq_out,
   output logic irq_oe
);
   if (DRV_MODE == irq_pkg::DRV_OPEN_DRAIN) begin : g_od
      assign irq_out = 1'b0;
      assign irq_oe  = pending;
   end else begin : g_pp
      assign irq_out = IRQ_ACTIVE_HIGH ? pending : ~pending;
      assign irq_oe  = 1'b1;
   end
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
   parameter int                NUM_REGS        = 4,
   parameter int                REG_W           = 8,
   parameter int                NUM_ALARMS      = 3,
   parameter int                ALARM_BASE      = 0,
   parameter irq_pkg::irq_drv_e DRV_MODE        = irq_pkg::DRV_PUSH_PULL,
   parameter bit                IRQ_ACTIVE_HIGH = 1'b1,
   localparam int               TOTAL           = NUM_REGS * REG_W,
   localparam int               SEL_W           = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [TOTAL-1:0]      evt_pulse,
   input  logic [NUM_ALARMS-1:0] alarm_lvl,
   input  logic                  alarm_any_edge,
   input  logic                  visible_mode,
   input  logic                  mask_wr,
   input  logic [SEL_W-1:0]      mask_sel,
   input  logic [REG_W-1:0]      mask_wdata,
   input  logic                  rd_en,
   input  logic [SEL_W-1:0]      rd_sel,
   output logic [REG_W-1:0]      rd_data,
   output logic                  irq_out,
   output logic                  irq_oe
);
   if (NUM_REGS < 1 || REG_W < 1) begin : g_bad_size
      $error("irq_status_bank: NUM_REGS and REG_W must be positive");
   end
   if (NUM_ALARMS < 1 || ALARM_BASE < 0 || ALARM_BASE + NUM_ALARMS > TOTAL) begin : g_bad_alarm
      $error("irq_status_bank: alarm bits fall outside the bank");
   end

   logic [NUM_ALARMS-1:0] alarm_evt;
   logic [TOTAL-1:0]      set_all;
   logic [TOTAL-1:0]      status_all;
   logic [TOTAL-1:0]      mask_all;
   logic [REG_W-1:0]      view_arr [NUM_REGS];
   logic [NUM_REGS-1:0]   pend_arr;
   logic [REG_W-1:0]      rd_view;

   irq_edge_detect #(.N(NUM_ALARMS)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl      (alarm_lvl),
      .any_edge (alarm_any_edge),
      .evt      (alarm_evt)
   );

   always_comb begin
      set_all = evt_pulse;
      for (int i = 0; i < NUM_ALARMS; i++) begin
         set_all[ALARM_BASE + i] = evt_pulse[ALARM_BASE + i] | alarm_evt[i];
      end
   end

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      logic rd_hit;
      logic mask_hit;
      assign rd_hit   = rd_en && (rd_sel == SEL_W'(r));
      assign mask_hit = mask_wr && (mask_sel == SEL_W'(r));

      irq_status_reg #(.W(REG_W)) u_reg (
         .clk        (clk),
         .rst_n      (rst_n),
         .set        (set_all[r*REG_W +: REG_W]),
         .visible    (visible_mode),
         .rd_hit     (rd_hit),
         .mask_hit   (mask_hit),
         .mask_wdata (mask_wdata),
         .status_q   (status_all[r*REG_W +: REG_W]),
         .mask_q     (mask_all[r*REG_W +: REG_W]),
         .view       (view_arr[r]),
         .pend       (pend_arr[r])
      );
   end

   always_comb begin
      rd_view = '0;
      for (int r = 0; r < NUM_REGS; r++) begin
         if (rd_sel == SEL_W'(r)) rd_view = view_arr[r];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_data <= '0;
      else if (rd_en) rd_data <= rd_view;
   end

   irq_out_driver #(
      .DRV_MODE        (DRV_MODE),
      .IRQ_ACTIVE_HIGH (IRQ_ACTIVE_HIGH)
   ) u_drv (
      .pending (|pend_arr),
      .irq_out (irq_out),
      .irq_oe  (irq_oe)
   );
endmodule

// File: rtl/irq_status_bank_chk.sv
module irq_status_bank_chk #(
   parameter int                NUM_REGS        = 4,
   parameter int                REG_W           = 8,
   parameter int                NUM_ALARMS      = 3,
   parameter int                ALARM_BASE      = 0,
   parameter irq_pkg::irq_drv_e DRV_MODE        = irq_pkg::DRV_PUSH_PULL,
   parameter bit                IRQ_ACTIVE_HIGH = 1'b1,
   localparam int               TOTAL           = NUM_REGS * REG_W,
   localparam int               SEL_W           = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [TOTAL-1:0]      evt_pulse,
   input logic [NUM_ALARMS-1:0] alarm_lvl,
   input logic                  visible_mode,
   input logic                  mask_wr,
   input logic                  rd_en,
   input logic [SEL_W-1:0]      rd_sel,
   input logic [REG_W-1:0]      rd_data,
   input logic                  irq_out,
   input logic                  irq_oe,
   input logic [TOTAL-1:0]      status_all,
   input logic [TOTAL-1:0]      mask_all
);
   logic irq_active;
   logic [REG_W-1:0] sel_mask;

   assign irq_active = (DRV_MODE == irq_pkg::DRV_OPEN_DRAIN) ? irq_oe
                                                             : (irq_out == IRQ_ACTIVE_HIGH);

   always_comb begin
      sel_mask = '0;
      for (int r = 0; r < NUM_REGS; r++) begin
         if (rd_sel == SEL_W'(r)) sel_mask = mask_all[r*REG_W +: REG_W];
      end
   end

   AST_IRQ_MATCHES_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      irq_active == (|(status_all & ~mask_all)));   // R9

   AST_EVT_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (!mask_wr && |(evt_pulse & ~mask_all)) |=> irq_active);   // R1

   AST_HIDDEN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !visible_mode) |=> ((rd_data & $past(sel_mask)) == '0));   // R3

   AST_NO_CLEAR_WITHOUT_READ: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> ((status_all & $past(status_all)) == $past(status_all)));   // R5

   AST_ALARM_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(alarm_lvl[0]) && (visible_mode || !mask_all[ALARM_BASE]))
      |=> status_all[ALARM_BASE]);   // R7
endmodule

bind irq_status_bank irq_status_bank_chk #(
   .NUM_REGS        (NUM_REGS),
   .REG_W           (REG_W),
   .NUM_ALARMS      (NUM_ALARMS),
   .ALARM_BASE      (ALARM_BASE),
   .DRV_MODE        (DRV_MODE),
   .IRQ_ACTIVE_HIGH (IRQ_ACTIVE_HIGH)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .evt_pulse    (evt_pulse),
   .alarm_lvl    (alarm_lvl),
   .visible_mode (visible_mode),
   .mask_wr      (mask_wr),
   .rd_en        (rd_en),
   .rd_sel       (rd_sel),
   .rd_data      (rd_data),
   .irq_out      (irq_out),
   .irq_oe       (irq_oe),
   .status_all   (status_all),
   .mask_all     (mask_all)
);

// File: tb/irq_status_bank_tb.sv
`timescale 1ns/1ps
module irq_status_bank_tb;
   localparam int NR = 4;
   localparam int RW = 8;
   localparam int NA = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NR*RW-1:0] evt_pulse = '0;
   logic [NA-1:0] alarm_lvl = '0;
   logic          alarm_any_edge = 1'b0;
   logic          visible_mode = 1'b0;
   logic          mask_wr = 1'b0;
   logic [1:0]    mask_sel = '0;
   logic [RW-1:0] mask_wdata = '0;
   logic          rd_en = 1'b0;
   logic [1:0]    rd_sel = '0;
   logic [RW-1:0] rd_data;
   logic          irq_out;
   logic          irq_oe;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   irq_status_bank u_dut (
      .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .alarm_lvl(alarm_lvl),
      .alarm_any_edge(alarm_any_edge), .visible_mode(visible_mode),
      .mask_wr(mask_wr), .mask_sel(mask_sel), .mask_wdata(mask_wdata),
      .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
      .irq_out(irq_out), .irq_oe(irq_oe)
   );

   typedef struct packed {
      logic [1:0] reg_i;
      logic [2:0] bit_i;
      logic [7:0] mask;
      logic       vis;
      logic [7:0] exp_rd;
      logic       exp_irq;
   } vec_t;

   localparam vec_t VECS [6] = '{
      '{2'd1, 3'd3, 8'h00, 1'b0, 8'h08, 1'b1},
      '{2'd2, 3'd7, 8'h80, 1'b0, 8'h00, 1'b0},
      '{2'd3, 3'd0, 8'h01, 1'b1, 8'h01, 1'b0},
      '{2'd1, 3'd5, 8'hDF, 1'b1, 8'h20, 1'b1},
      '{2'd2, 3'd4, 8'hEF, 1'b0, 8'h10, 1'b1},
      '{2'd3, 3'd6, 8'hFF, 1'b0, 8'h00, 1'b0}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic write_mask(input int r, input logic [7:0] m);
      mask_wr = 1'b1; mask_sel = 2'(r); mask_wdata = m;
      step();
      mask_wr = 1'b0;
   endtask

   task automatic pulse(input int r, input int b);
      evt_pulse = '0; evt_pulse[r*RW + b] = 1'b1;
      step();
      evt_pulse = '0;
   endtask

   task automatic read_reg(input int r);
      rd_en = 1'b1; rd_sel = 2'(r);
      step();
      rd_en = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      step(); step();
      rst_n = 1'b1;
      step();
      // R11 reset state, R10 push-pull enable
      check("R11 rd_data after reset", rd_data, 0);
      check("R11 irq after reset", irq_out, 0);
      check("R10 push-pull oe", irq_oe, 1);
      // R11 masks reset to ones: event is neither recorded nor raises irq
      pulse(1, 0);
      check("R11 masked by default irq", irq_out, 0);
      read_reg(1);
      check("R11 masked by default read", rd_data, 0);

      // vector walk: R1 R2 R3 R4 R5 R12
      foreach (VECS[i]) begin
         visible_mode = VECS[i].vis;
         write_mask(int'(VECS[i].reg_i), VECS[i].mask);
         pulse(int'(VECS[i].reg_i), int'(VECS[i].bit_i));
         check("R1/R2 irq after event", irq_out, VECS[i].exp_irq);
         read_reg(int'(VECS[i].reg_i));
         check("R3/R4/R12 read value", rd_data, VECS[i].exp_rd);
         check("R5 irq after clearing read", irq_out, 0);
      end
      visible_mode = 1'b0;

      // R6: event in the same cycle as a read of its register
      write_mask(1, 8'h00);
      pulse(1, 2);
      rd_en = 1'b1; rd_sel = 2'd1; evt_pulse[1*RW + 2] = 1'b1;
      step();
      rd_en = 1'b0; evt_pulse = '0;
      check("R6 snapshot", rd_data, 8'h04);
      check("R6 irq kept", irq_out, 1);
      read_reg(1);
      check("R6 event kept", rd_data, 8'h04);
      check("R6 irq cleared", irq_out, 0);

      // R9: OR across registers
      write_mask(2, 8'hFD);
      write_mask(3, 8'hFD);
      evt_pulse[2*RW + 1] = 1'b1; evt_pulse[3*RW + 1] = 1'b1;
      step();
      evt_pulse = '0;
      read_reg(2);
      check("R9 other reg still pending", irq_out, 1);
      read_reg(3);
      check("R9 bank idle", irq_out, 0);

      // R5 visible: read clears masked and unmasked alike
      visible_mode = 1'b1;
      write_mask(3, 8'hFF);
      evt_pulse[3*RW + 0] = 1'b1; evt_pulse[3*RW + 4] = 1'b1;
      step();
      evt_pulse = '0;
      check("R4 masked visible no irq", irq_out, 0);
      read_reg(3);
      check("R5 visible read all", rd_data, 8'h11);
      read_reg(3);
      check("R5 visible cleared", rd_data, 8'h00);
      visible_mode = 1'b0;

      // R7 rising-only alarm
      write_mask(0, 8'h00);
      alarm_any_edge = 1'b0;
      alarm_lvl[1] = 1'b1;
      step();
      check("R7 rise irq", irq_out, 1);
      read_reg(0);
      check("R7 rise bit", rd_data, 8'h02);
      alarm_lvl[1] = 1'b0;
      step();
      check("R7 fall ignored irq", irq_out, 0);
      read_reg(0);
      check("R7 fall ignored read", rd_data, 8'h00);

      // R8 both-edge alarm
      alarm_any_edge = 1'b1;
      alarm_lvl[2] = 1'b1;
      step();
      read_reg(0);
      check("R8 rise bit", rd_data, 8'h04);
      alarm_lvl[2] = 1'b0;
      step();
      check("R8 fall irq", irq_out, 1);
      read_reg(0);
      check("R8 fall bit", rd_data, 8'h04);
      check("R10 oe still driven", irq_oe, 1);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule